// File: doc/BRIEF.md
# Teletext Bit Slicer with Data-Clock Recovery

This block turns a stream of digitized composite-video samples into teletext data bits. A line-start strobe arms it, and a window strobe marks the clock run-in that opens every teletext line. While that window is open, the block builds a decision threshold from the mean of the most recent run-in samples. A numerically controlled phase accumulator also trains its phase and rate on the edges of the thresholded signal.

When the window closes, the threshold and the accumulator rate stop adapting, because NRZ payload has no reliable mean and no guaranteed edges. From then on, the free-running accumulator wraps once per bit period. At each wrap the block emits the thresholded value with a one-cycle valid strobe. The first eight emitted bits are matched against the framing byte, least significant bit first. On a match, a sticky flag rises and stays high until the next line start. Timing-strobe generation and byte assembly are handled by neighbouring blocks.

Top module: `ttx_bit_slicer`

## Requirements
- R1: After reset, `bit_vld_o` and `frame_ok_o` are low, and both stay low until a run-in window has been seen and closed.
- R2: The threshold is the integer mean (sum divided by 16, truncated) of the last 16 samples taken while `runin_i` is high after the latest line start.
- R3: The threshold is frozen once the run-in window closes: payload samples of any level do not move it before the next line start.
- R4: A sample strictly greater than the threshold slices to 1; a sample equal to or below it slices to 0.
- R5: No bit is emitted between a line start and the close of its run-in window.
- R6: After the window closes, one bit is emitted per accumulator wrap, in arrival order. With a nominal increment of 2^16/4 and 4 samples per bit, consecutive strobes are exactly 4 cycles apart.
- R7: During the window, once 16 run-in samples have been collected, each slice edge corrects the accumulator phase and increment toward an edge phase of one half. A nominal increment off by a few percent still decodes the payload correctly.
- R8: After the window closes, neither the increment nor the phase reacts to payload edges. A payload shifted late by half a bit is sampled at the old bit centres and comes out delayed by one bit.
- R9: `frame_ok_o` rises with the strobe of the 8th emitted bit if those 8 bits, taken first bit as bit 0, equal 0xE4. It then stays high until the next line start.
- R10: If the first 8 bits differ from 0xE4, `frame_ok_o` stays low for the line, even if 0xE4 appears later in the stream.
- R11: A line start clears `frame_ok_o`, the bit strobe and the threshold window in the next cycle, and reloads the accumulator with the nominal increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle strobe that re-arms the block for a new line |
| runin_i | input | 1 | High while clock run-in samples are present |
| smp_i | input | SMP_W (8) | Digitized video sample, unsigned |
| nom_inc_i | input | PH_W (16) | Nominal accumulator increment per sample (2^PH_W / samples per bit) |
| bit_o | output | 1 | Recovered data bit |
| bit_vld_o | output | 1 | One-cycle strobe marking `bit_o` as a new bit |
| frame_ok_o | output | 1 | Framing byte found in the first 8 bits of this line |

## Verification
A wrong threshold shows up at the ports at the first payload bit. This is measured most sharply by payload samples one code above and exactly at the expected mean, which flip bits at once. A threshold that leaks into the payload shows up as a long constant payload that slices to the wrong value within a bit or two of the window closing. A loop that keeps tracking after the window shows up when the payload is shifted by half a bit: a frozen loop returns the stream one bit late from the first strobe, while a tracking one drifts back within a few edges. Errors in rate training show up only over a full line, as slipped or doubled bits near its end when the nominal increment is mistuned.

// File: rtl/ttx_pkg.sv
package ttx_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_RUNIN = 2'd1,
        ST_DATA  = 2'd2
    } slc_state_e;

endpackage

// File: rtl/ttx_level_est.sv
module ttx_level_est #(
    parameter int SMP_W    = 8,
    parameter int WIN_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             upd_i,
    input  logic [SMP_W-1:0] smp_i,
    output logic [SMP_W-1:0] level_o,
    output logic             full_o
);
    localparam int N     = 1 << WIN_LOG2;
    localparam int SUM_W = SMP_W + WIN_LOG2;
    localparam int CNT_W = WIN_LOG2 + 1;

    typedef struct packed {
        logic [N-1:0][SMP_W-1:0] win;
        logic [SUM_W-1:0]        sum;
        logic [CNT_W-1:0]        cnt;
    } lvl_t;

    lvl_t lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (clr_i) begin
            lvl_d = '0;
        end else if (upd_i) begin
            lvl_d.win = {lvl_q.win[N-2:0], smp_i};
            lvl_d.sum = lvl_q.sum + SUM_W'(smp_i) - SUM_W'(lvl_q.win[N-1]);
            if (lvl_q.cnt != CNT_W'(N)) begin
                lvl_d.cnt = lvl_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign level_o = lvl_q.sum[SUM_W-1:WIN_LOG2];
    assign full_o  = (lvl_q.cnt == CNT_W'(N));

endmodule

// File: rtl/ttx_dpll.sv
module ttx_dpll #(
    parameter int PH_W  = 16,
    parameter int KP_SH = 2,
    parameter int KI_SH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            train_i,
    input  logic [PH_W-1:0] nom_inc_i,
    output logic            wrap_o,
    output logic [PH_W-1:0] inc_o
);
    localparam logic [PH_W-1:0] HALF = PH_W'(1) << (PH_W - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic [PH_W-1:0] inc;
    } nco_t;

    nco_t nco_d, nco_q;
    logic [PH_W:0]          step;
    logic signed [PH_W-1:0] err;
    logic signed [PH_W-1:0] p_corr;
    logic signed [PH_W-1:0] f_corr;

    always_comb begin
        step   = {1'b0, nco_q.phase} + {1'b0, nco_q.inc};
        err    = $signed(nco_q.phase - HALF);
        p_corr = err >>> KP_SH;
        f_corr = err >>> KI_SH;
        nco_d  = nco_q;
        if (clr_i) begin
            nco_d.phase = '0;
            nco_d.inc   = nom_inc_i;
        end else if (train_i) begin
            nco_d.phase = step[PH_W-1:0] - $unsigned(p_corr);
            nco_d.inc   = nco_q.inc - $unsigned(f_corr);
        end else begin
            nco_d.phase = step[PH_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nco_q <= '0;
        else        nco_q <= nco_d;
    end

    assign wrap_o = step[PH_W];
    assign inc_o  = nco_q.inc;

endmodule

// File: rtl/ttx_frame_det.sv
module ttx_frame_det #(
    parameter int          LEN  = 8,
    parameter logic [7:0]  CODE = 8'hE4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic bit_i,
    output logic ok_o
);
    localparam int CNT_W = $clog2(LEN + 1);

    typedef struct packed {
        logic [LEN-1:0]   sh;
        logic [CNT_W-1:0] cnt;
        logic             ok;
    } fdet_t;

    fdet_t fd_d, fd_q;
    logic [LEN-1:0] sh_next;

    always_comb begin
        fd_d    = fd_q;
        sh_next = {bit_i, fd_q.sh[LEN-1:1]};
        if (clr_i) begin
            fd_d = '0;
        end else if (en_i && (fd_q.cnt != CNT_W'(LEN))) begin
            fd_d.sh  = sh_next;
            fd_d.cnt = fd_q.cnt + CNT_W'(1);
            if (fd_q.cnt == CNT_W'(LEN - 1)) begin
                fd_d.ok = (sh_next == CODE[LEN-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fd_q <= '0;
        else        fd_q <= fd_d;
    end

    assign ok_o = fd_q.ok;

endmodule

// File: rtl/ttx_bit_slicer.sv
module ttx_bit_slicer
    import ttx_pkg::*;
#(
    parameter int         SMP_W    = 8,
    parameter int         WIN_LOG2 = 4,
    parameter int         PH_W     = 16,
    parameter int         KP_SH    = 2,
    parameter int         KI_SH    = 4,
    parameter logic [7:0] FR_CODE  = 8'hE4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start_i,
    input  logic             runin_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic [PH_W-1:0]  nom_inc_i,
    output logic             bit_o,
    output logic             bit_vld_o,
    output logic             frame_ok_o
);
    localparam int FR_LEN = 8;

    typedef struct packed {
        slc_state_e st;
        logic       slc;
        logic       slc_prev;
        logic       bit_v;
        logic       vld;
    } top_t;

    top_t s_d, s_q;

    logic [SMP_W-1:0] lvl_w;
    logic             full_w;
    logic             wrap_w;
    logic [PH_W-1:0]  inc_w;
    logic             lvl_upd;
    logic             train;
    logic             emit;

    always_comb begin
        lvl_upd = runin_i && (s_q.st != ST_DATA) && !line_start_i;
        train   = runin_i && (s_q.st != ST_DATA) && full_w
                  && (s_q.slc != s_q.slc_prev) && !line_start_i;
        emit    = (s_q.st == ST_DATA) && wrap_w && !line_start_i;

        s_d          = s_q;
        s_d.vld      = 1'b0;
        s_d.slc      = (smp_i > lvl_w);
        s_d.slc_prev = s_q.slc;

        if (line_start_i) begin
            s_d.st       = ST_WAIT;
            s_d.slc_prev = 1'b0;
            s_d.slc      = 1'b0;
        end else begin
            unique case (s_q.st)
                ST_WAIT:  if (runin_i)  s_d.st = ST_RUNIN;
                ST_RUNIN: if (!runin_i) s_d.st = ST_DATA;
                default:  s_d.st = ST_DATA;
            endcase
            if (emit) begin
                s_d.bit_v = s_q.slc;
                s_d.vld   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_WAIT, default: '0};
        else        s_q <= s_d;
    end

    ttx_level_est #(
        .SMP_W    (SMP_W),
        .WIN_LOG2 (WIN_LOG2)
    ) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (line_start_i),
        .upd_i   (lvl_upd),
        .smp_i   (smp_i),
        .level_o (lvl_w),
        .full_o  (full_w)
    );

    ttx_dpll #(
        .PH_W  (PH_W),
        .KP_SH (KP_SH),
        .KI_SH (KI_SH)
    ) u_dpll (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (line_start_i),
        .train_i   (train),
        .nom_inc_i (nom_inc_i),
        .wrap_o    (wrap_w),
        .inc_o     (inc_w)
    );

    ttx_frame_det #(
        .LEN  (FR_LEN),
        .CODE (FR_CODE)
    ) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (line_start_i),
        .en_i  (emit),
        .bit_i (s_q.slc),
        .ok_o  (frame_ok_o)
    );

    assign bit_o     = s_q.bit_v;
    assign bit_vld_o = s_q.vld;

endmodule

// File: rtl/ttx_bit_slicer_chk.sv
module ttx_bit_slicer_chk #(
    parameter int SMP_W = 8,
    parameter int PH_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_start_i,
    input logic             bit_vld_o,
    input logic             frame_ok_o,
    input logic             in_data,
    input logic             lvl_upd,
    input logic [SMP_W-1:0] level,
    input logic [PH_W-1:0]  inc
);
    assert_level_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_upd && !line_start_i) |=> $stable(level));

    assert_no_bit_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_data |=> !bit_vld_o);

    assert_inc_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !line_start_i) |=> $stable(inc));

    assert_frame_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok_o && !line_start_i) |=> frame_ok_o);

    assert_frame_rise_on_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_ok_o) |-> bit_vld_o);

    assert_line_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_i |=> (!frame_ok_o && !bit_vld_o));

endmodule

bind ttx_bit_slicer ttx_bit_slicer_chk #(
    .SMP_W (SMP_W),
    .PH_W  (PH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start_i (line_start_i),
    .bit_vld_o    (bit_vld_o),
    .frame_ok_o   (frame_ok_o),
    .in_data      (s_q.st == ttx_pkg::ST_DATA),
    .lvl_upd      (lvl_upd),
    .level        (lvl_w),
    .inc          (inc_w)
);

// File: tb/ttx_bit_slicer_tb.sv
module ttx_bit_slicer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SPB        = 4;
    localparam int NOM        = 16384;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start_i = 1'b0;
    logic       runin_i = 1'b0;
    logic [7:0] smp_i = 8'd0;
    logic [15:0] nom_inc_i = 16'(NOM);
    logic       bit_o, bit_vld_o, frame_ok_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rx_n = 0;
    logic rx [0:127];
    int   rx_t [0:127];
    logic exp_bits [0:23];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (bit_vld_o && rx_n < 128) begin
            rx[rx_n]   = bit_o;
            rx_t[rx_n] = cyc;
            rx_n       = rx_n + 1;
        end
    end

    ttx_bit_slicer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start_i),
        .runin_i      (runin_i),
        .smp_i        (smp_i),
        .nom_inc_i    (nom_inc_i),
        .bit_o        (bit_o),
        .bit_vld_o    (bit_vld_o),
        .frame_ok_o   (frame_ok_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drives one line: line start, one idle sample, 16 run-in bits,
    // an optional gap, then 24 payload bits (LSB first) and an idle tail.
    task automatic drive_line(input logic [7:0] hr, input logic [7:0] lr,
                              input logic [7:0] hd, input logic [7:0] ld,
                              input logic [23:0] pay, input int gap,
                              input logic all_hi);
        @(negedge clk);
        line_start_i = 1'b1; runin_i = 1'b0; smp_i = lr;
        @(negedge clk);
        line_start_i = 1'b0;
        rx_n = 0;
        for (int b = 0; b < 16; b++) begin
            for (int s = 0; s < SPB; s++) begin
                @(negedge clk);
                runin_i = 1'b1;
                smp_i = (b % 2 == 0) ? hr : lr;
            end
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            runin_i = 1'b0; smp_i = ld;
        end
        for (int b = 0; b < 24; b++) begin
            for (int s = 0; s < SPB; s++) begin
                @(negedge clk);
                runin_i = 1'b0;
                smp_i = (all_hi || pay[b]) ? hd : ld;
            end
        end
        for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            smp_i = ld;
        end
    endtask

    task automatic cmp_bits(input string req, input logic [23:0] pay, input int shift);
        for (int k = 0; k < 24; k++) begin
            logic e;
            e = (k < shift) ? 1'b0 : pay[k - shift];
            chk(req, int'(rx[k]), int'(e));
        end
    endtask

    task automatic t_reset;
        chk("R1 bit_vld after reset", int'(bit_vld_o), 0);
        chk("R1 frame_ok after reset", int'(frame_ok_o), 0);
    endtask

    task automatic t_tuned;
        logic [23:0] pay = {8'hC3, 8'h5A, 8'hE4};
        fork
            drive_line(8'd200, 8'd40, 8'd200, 8'd40, pay, 0, 1'b0);
            begin
                // end of run-in: line start negedge + 1 idle + 64 run-in cycles
                repeat (66) @(negedge clk);
                #1 chk("R5 no bits during run-in", rx_n, 0);
            end
        join
        chk("R6 bit count", int'(rx_n >= 24), 1);
        cmp_bits("R6 tuned payload", pay, 0);
        chk("R6 strobe spacing", rx_t[1] - rx_t[0], 4);
        chk("R6 eight-bit span", rx_t[8] - rx_t[0], 32);
        chk("R9 frame found", int'(frame_ok_o), 1);
    endtask

    task automatic t_exact_level;
        logic [23:0] pay = {8'h0F, 8'h33, 8'hE4};
        drive_line(8'd90, 8'd10, 8'd51, 8'd50, pay, 0, 1'b0);
        cmp_bits("R2 R4 threshold 50", pay, 0);
        chk("R9 frame found at low level", int'(frame_ok_o), 1);
    endtask

    task automatic t_freeze;
        drive_line(8'd200, 8'd40, 8'd200, 8'd40, 24'h000000, 0, 1'b1);
        cmp_bits("R3 constant high payload", 24'hFFFFFF, 0);
        chk("R10 no frame on 0xFF", int'(frame_ok_o), 0);
    endtask

    task automatic t_mismatch;
        logic [23:0] pay = {8'h00, 8'hE4, 8'h27};
        @(negedge clk);
        line_start_i = 1'b1;
        @(negedge clk);
        line_start_i = 1'b0;
        chk("R11 frame_ok cleared", int'(frame_ok_o), 0);
        drive_line(8'd200, 8'd40, 8'd200, 8'd40, pay, 0, 1'b0);
        cmp_bits("R10 payload", pay, 0);
        chk("R10 late code ignored", int'(frame_ok_o), 0);
    endtask

    task automatic t_mistuned(input int inc);
        logic [23:0] pay = {8'h96, 8'h3C, 8'hE4};
        nom_inc_i = 16'(inc);
        drive_line(8'd200, 8'd40, 8'd200, 8'd40, pay, 0, 1'b0);
        cmp_bits("R7 mistuned payload", pay, 0);
        chk("R7 frame with mistuned loop", int'(frame_ok_o), 1);
        nom_inc_i = 16'(NOM);
    endtask

    task automatic t_late_payload;
        logic [23:0] pay = {8'hA5, 8'h3C, 8'hE4};
        drive_line(8'd200, 8'd40, 8'd200, 8'd40, pay, 2, 1'b0);
        cmp_bits("R8 loop holds phase", pay, 1);
        chk("R8 shifted code not matched", int'(frame_ok_o), 0);
    endtask

    logic done = 1'b0;

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_tuned();
        t_exact_level();
        t_freeze();
        t_tuned();
        t_mismatch();
        t_mistuned(16200);
        t_mistuned(16560);
        t_late_payload();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule